// File: doc/BRIEF.md
# Nonvolatile memory write-unlock sequencer

This block guards the start of every self-programming operation on an on-chip nonvolatile memory. It sits on a CPU register-write bus next to the memory controller. It exposes two byte-wide registers: a control register and a key register. A write or erase is launched only when three bus cycles run back to back. The first writes the first key byte to the key register. The second writes the second key byte to the key register. The third writes the control register with its start bit set. The enable bit must already hold 1 from an earlier write.

If a cycle is missed, a value is wrong or any other bus access comes in between, the sequence is cancelled without a word. A start request that arrives without the full sequence is dropped and raises a sticky fault bit. Software can read that bit back and clear it.

An accepted request launches one of five operations, chosen by a 3-bit field: row erase, program-latch commit, ID-latch commit, data write or configuration write. The run time of each operation is a parameter, counted by an internal timer. While the operation runs, the block holds a stall output to the CPU and reads the start bit back as 1. When the operation ends, it drops the stall, clears the start bit and gives a one-cycle done pulse.

Top module: `nvm_unlock_guard`

## Requirements
- R1: After reset the stall and done outputs are low and the control register reads back as 00h (start, enable, fault and operation field all zero).
- R2: An operation launches only after three consecutive bus cycles: a write of 55h to the key register (address 1), then a write of AAh to the key register, then a control-register write (address 0) with bit 0 (start) set.
- R3: The enable bit (control bit 1) must already hold 1 before the start write; setting it in the start write itself does not allow the launch.
- R4: A cycle with no bus access, a key write of any other value, or any other access (including a read) between the steps cancels the sequence, and a following start write launches nothing.
- R5: A key write of 55h restarts tracking at the first step from any tracker state, so 55h, 55h, AAh, start launches the operation.
- R6: A start write that is not accepted sets the sticky fault bit (control bit 2). A control write with bit 2 set clears the fault bit, unless that same write is a rejected start.
- R7: The operation field is control bits 6:4: 0 row erase, 1 program-latch commit, 2 ID-latch commit, 3 data write, 4 configuration write. Codes 5 to 7 are rejected as a failed start.
- R8: After an accepted start write, the stall output is high from the next cycle for exactly the parameter duration of the chosen operation (defaults 24, 16, 12, 20 and 10 cycles).
- R9: Control bit 0 reads back as 1 while the operation runs. In the first cycle after the stall drops, done is high for exactly one cycle and bit 0 reads 0.
- R10: While an operation runs, key writes are ignored, a start write is rejected (R6), and the operation field keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_valid | input | 1 | Bus access in this cycle |
| bus_we | input | 1 | Access is a write (1) or a read (0) |
| bus_addr | input | ADDR_W | Register address: control at CTRL_ADDR, key at KEY_ADDR |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (control register, otherwise 00h) |
| stall_o | output | 1 | Holds the CPU while an operation runs |
| done_o | output | 1 | One-cycle pulse when an operation ends |
| op_o | output | 3 | Operation field, stable while an operation runs |

## Verification
The main function is tried with the exact three-cycle pattern for each of the five operation codes, which confirms both the launch and each operation's duration. It is then tried with patterns that differ from the exact one in a single way: a one-cycle gap, a wrong second key, a read squeezed between the steps, enable cleared, enable set only in the start write, and an invalid operation code. Each of these separates the one faulty step from a correct launch. Repeated first keys and a stray second key ahead of the first show that the tracker restarts rather than locks up. A full sequence written while an operation is already running shows that the busy state blocks both the keys and the start.

// File: rtl/nvm_unlock_pkg.sv
package nvm_unlock_pkg;

    typedef enum logic [1:0] {
        KS_IDLE  = 2'd0,
        KS_FIRST = 2'd1,
        KS_ARMED = 2'd2
    } key_state_e;

    // operation codes carried in the control register field
    localparam logic [2:0] OP_ROW_ERASE   = 3'd0;
    localparam logic [2:0] OP_PROG_COMMIT = 3'd1;
    localparam logic [2:0] OP_ID_COMMIT   = 3'd2;
    localparam logic [2:0] OP_DATA_WRITE  = 3'd3;
    localparam logic [2:0] OP_CFG_WRITE   = 3'd4;
    localparam logic [2:0] OP_LAST        = OP_CFG_WRITE;

    // control register bit positions (software visible)
    localparam int CTRL_GO_BIT    = 0;
    localparam int CTRL_EN_BIT    = 1;
    localparam int CTRL_FAULT_BIT = 2;
    localparam int CTRL_OP_LSB    = 4;

    typedef struct packed {
        logic       en;
        logic       fault;
        logic [2:0] op;
    } ctrl_regs_t;

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/nvm_key_tracker.sv
module nvm_key_tracker
    import nvm_unlock_pkg::*;
#(
    parameter logic [7:0] KEY_FIRST  = 8'h55,
    parameter logic [7:0] KEY_SECOND = 8'hAA
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       key_wr,
    input  logic [7:0] key_data,
    input  logic       busy,
    output logic       armed
);

    key_state_e state_d, state_q;

    always_comb begin
        state_d = KS_IDLE;
        if (!busy && key_wr) begin
            if (key_data == KEY_FIRST) begin
                state_d = KS_FIRST;
            end else if (key_data == KEY_SECOND && state_q == KS_FIRST) begin
                state_d = KS_ARMED;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= KS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign armed = (state_q == KS_ARMED);

endmodule

// File: rtl/nvm_busy_timer.sv
module nvm_busy_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] load_val,
    output logic             busy,
    output logic             done
);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [CNT_W-1:0] cnt;
    } timer_t;

    timer_t tmr_d, tmr_q;

    always_comb begin
        tmr_d      = tmr_q;
        tmr_d.done = 1'b0;
        if (tmr_q.busy) begin
            if (tmr_q.cnt == '0) begin
                tmr_d.busy = 1'b0;
                tmr_d.done = 1'b1;
            end else begin
                tmr_d.cnt = tmr_q.cnt - 1'b1;
            end
        end else if (start) begin
            tmr_d.busy = 1'b1;
            tmr_d.cnt  = load_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign busy = tmr_q.busy;
    assign done = tmr_q.done;

endmodule

// File: rtl/nvm_unlock_guard.sv
module nvm_unlock_guard
    import nvm_unlock_pkg::*;
#(
    parameter int          ADDR_W         = 4,
    parameter int          CTRL_ADDR      = 0,
    parameter int          KEY_ADDR       = 1,
    parameter logic [7:0]  KEY_FIRST      = 8'h55,
    parameter logic [7:0]  KEY_SECOND     = 8'hAA,
    parameter int unsigned DUR_ROW_ERASE  = 24,
    parameter int unsigned DUR_PROG       = 16,
    parameter int unsigned DUR_ID         = 12,
    parameter int unsigned DUR_DATA       = 20,
    parameter int unsigned DUR_CFG        = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              stall_o,
    output logic              done_o,
    output logic [2:0]        op_o
);

    localparam int unsigned DUR_MAX = max_u(max_u(max_u(DUR_ROW_ERASE, DUR_PROG),
                                                  max_u(DUR_ID, DUR_DATA)), DUR_CFG);
    localparam int CNT_W = (DUR_MAX > 1) ? $clog2(DUR_MAX) : 1;

    ctrl_regs_t regs_d, regs_q;

    logic             key_wr, ctrl_wr;
    logic             armed, busy, done;
    logic             go_req, op_ok, accept, reject;
    logic [2:0]       op_field;
    logic [CNT_W-1:0] load_val;

    assign key_wr  = bus_valid && bus_we && (bus_addr == ADDR_W'(KEY_ADDR));
    assign ctrl_wr = bus_valid && bus_we && (bus_addr == ADDR_W'(CTRL_ADDR));

    nvm_key_tracker #(
        .KEY_FIRST (KEY_FIRST),
        .KEY_SECOND(KEY_SECOND)
    ) u_tracker (
        .clk     (clk),
        .rst_n   (rst_n),
        .key_wr  (key_wr),
        .key_data(bus_wdata),
        .busy    (busy),
        .armed   (armed)
    );

    // start decision and register update
    always_comb begin
        regs_d   = regs_q;
        go_req   = ctrl_wr && bus_wdata[CTRL_GO_BIT];
        op_field = bus_wdata[CTRL_OP_LSB +: 3];
        op_ok    = (op_field <= OP_LAST);
        accept   = go_req && armed && regs_q.en && !busy && op_ok;
        reject   = go_req && !accept;
        if (ctrl_wr) begin
            regs_d.en = bus_wdata[CTRL_EN_BIT];
            if (!busy) begin
                regs_d.op = op_field;
            end
        end
        if (reject) begin
            regs_d.fault = 1'b1;
        end else if (ctrl_wr && bus_wdata[CTRL_FAULT_BIT]) begin
            regs_d.fault = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    // per-operation run length, minus one for the down-counter
    always_comb begin
        case (op_field)
            OP_ROW_ERASE:   load_val = CNT_W'(DUR_ROW_ERASE - 1);
            OP_PROG_COMMIT: load_val = CNT_W'(DUR_PROG - 1);
            OP_ID_COMMIT:   load_val = CNT_W'(DUR_ID - 1);
            OP_DATA_WRITE:  load_val = CNT_W'(DUR_DATA - 1);
            default:        load_val = CNT_W'(DUR_CFG - 1);
        endcase
    end

    nvm_busy_timer #(
        .CNT_W(CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (accept),
        .load_val(load_val),
        .busy    (busy),
        .done    (done)
    );

    always_comb begin
        bus_rdata = 8'h00;
        if (bus_addr == ADDR_W'(CTRL_ADDR)) begin
            bus_rdata[CTRL_GO_BIT]            = busy;
            bus_rdata[CTRL_EN_BIT]            = regs_q.en;
            bus_rdata[CTRL_FAULT_BIT]         = regs_q.fault;
            bus_rdata[CTRL_OP_LSB +: 3]       = regs_q.op;
        end
    end

    assign stall_o = busy;
    assign done_o  = done;
    assign op_o    = regs_q.op;

endmodule

// File: rtl/nvm_unlock_guard_chk.sv
module nvm_unlock_guard_chk #(
    parameter int         ADDR_W     = 4,
    parameter int         CTRL_ADDR  = 0,
    parameter int         KEY_ADDR   = 1,
    parameter logic [7:0] KEY_FIRST  = 8'h55,
    parameter logic [7:0] KEY_SECOND = 8'hAA
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_wdata,
    input logic              stall_o,
    input logic              done_o,
    input logic [2:0]        op_o,
    input logic              fault
);

    logic key1_wr, key2_wr, go_wr;
    assign key1_wr = bus_valid && bus_we && (bus_addr == ADDR_W'(KEY_ADDR)) && (bus_wdata == KEY_FIRST);
    assign key2_wr = bus_valid && bus_we && (bus_addr == ADDR_W'(KEY_ADDR)) && (bus_wdata == KEY_SECOND);
    assign go_wr   = bus_valid && bus_we && (bus_addr == ADDR_W'(CTRL_ADDR)) && bus_wdata[0];

    assert_launch_needs_keys_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stall_o) |-> ($past(go_wr, 1) && $past(key2_wr, 2) && $past(key1_wr, 3)));

    assert_launch_op_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stall_o) |-> (op_o <= 3'd4));

    assert_fault_from_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault) |-> $past(go_wr));

    assert_done_after_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!stall_o && $past(stall_o)));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_stall_ends_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stall_o) |-> done_o);

    assert_op_stable_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_o && $past(stall_o)) |-> $stable(op_o));

endmodule

bind nvm_unlock_guard nvm_unlock_guard_chk #(
    .ADDR_W    (ADDR_W),
    .CTRL_ADDR (CTRL_ADDR),
    .KEY_ADDR  (KEY_ADDR),
    .KEY_FIRST (KEY_FIRST),
    .KEY_SECOND(KEY_SECOND)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_valid(bus_valid),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .stall_o  (stall_o),
    .done_o   (done_o),
    .op_o     (op_o),
    .fault    (regs_q.fault)
);

// File: tb/nvm_unlock_guard_test.sv
module nvm_unlock_guard_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_valid = 1'b0;
    logic       bus_we = 1'b0;
    logic [3:0] bus_addr = 4'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       stall_o, done_o;
    logic [2:0] op_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string cur_req = "R1";

    // reference model state
    int m_st = 0;
    int m_rem = 0;
    bit m_done = 0, m_en = 0, m_fault = 0;
    int m_op = 0;
    int dut_rises = 0, dut_dones = 0;
    bit prev_stall = 0;

    always #5 clk = ~clk;

    nvm_unlock_guard uut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .stall_o(stall_o), .done_o(done_o), .op_o(op_o)
    );

    function automatic int dur_of(input int op);
        case (op)
            0: return 24;
            1: return 16;
            2: return 12;
            3: return 20;
            default: return 10;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cycles);
        end
    endtask

    always @(posedge clk) begin
        bit pre_busy, pre_en, kw, cw, go, acc;
        int pre_st, opv, exp_rd;
        cycles++;
        if (!rst_n) begin
            m_st = 0; m_rem = 0; m_done = 0; m_en = 0; m_fault = 0; m_op = 0;
        end else begin
            pre_busy = (m_rem > 0);
            pre_st   = m_st;
            pre_en   = m_en;
            if (m_rem > 0) begin
                m_rem--;
                m_done = (m_rem == 0);
            end else begin
                m_done = 0;
            end
            kw = bus_valid && bus_we && (bus_addr == 4'd1);
            cw = bus_valid && bus_we && (bus_addr == 4'd0);
            if (pre_busy || !kw) m_st = 0;
            else if (bus_wdata == 8'h55) m_st = 1;
            else if (bus_wdata == 8'hAA && pre_st == 1) m_st = 2;
            else m_st = 0;
            if (cw) begin
                go  = bus_wdata[0];
                opv = int'(bus_wdata[6:4]);
                acc = go && pre_st == 2 && pre_en && !pre_busy && opv <= 4;
                if (go && !acc) m_fault = 1;
                else if (bus_wdata[2]) m_fault = 0;
                m_en = bus_wdata[1];
                if (!pre_busy) m_op = opv;
                if (acc) m_rem = dur_of(opv);
            end
        end
        #2;
        if (rst_n) begin
            if (stall_o && !prev_stall) dut_rises++;
            if (done_o) dut_dones++;
            prev_stall = stall_o;
            chk(stall_o == (m_rem > 0), {cur_req, "/R8 stall"}, int'(stall_o), int'(m_rem > 0));
            chk(done_o == m_done, {cur_req, "/R9 done"}, int'(done_o), int'(m_done));
            exp_rd = (bus_addr == 4'd0) ?
                     ((m_op << 4) | (int'(m_fault) << 2) | (int'(m_en) << 1) | int'(m_rem > 0)) : 0;
            chk(int'(bus_rdata) == exp_rd, {cur_req, "/R9 readback"}, int'(bus_rdata), exp_rd);
            chk(int'(op_o) == m_op, {cur_req, "/R10 op"}, int'(op_o), m_op);
        end
    end

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    endtask

    task automatic rd(input logic [3:0] a);
        @(negedge clk);
        bus_valid = 1'b1; bus_we = 1'b0; bus_addr = a; bus_wdata = 8'h00;
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        bus_valid = 1'b0; bus_we = 1'b0; bus_addr = 4'd0; bus_wdata = 8'h00;
        for (int i = 1; i < n; i++) @(negedge clk);
    endtask

    task automatic unlock_go(input logic [7:0] ctrl);
        wr(4'd1, 8'h55);
        wr(4'd1, 8'hAA);
        wr(4'd0, ctrl);
    endtask

    task automatic expect_fault(input bit exp, input string req);
        idle(2);
        chk(bus_rdata[2] == exp, req, int'(bus_rdata[2]), int'(exp));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        cur_req = "R1";
        chk(stall_o == 1'b0, "R1 stall after reset", int'(stall_o), 0);
        chk(done_o == 1'b0, "R1 done after reset", int'(done_o), 0);
        chk(bus_rdata == 8'h00, "R1 control after reset", int'(bus_rdata), 0);
        rst_n = 1'b1;
        idle(2);

        cur_req = "R2";
        wr(4'd0, 8'h02);
        for (int op = 0; op < 5; op++) begin
            cur_req = (op == 0) ? "R2" : "R7";
            unlock_go(8'(8'h03 | (op << 4)));
            idle(30);
        end
        chk(dut_rises == 5, "R8 five launches", dut_rises, 5);
        chk(dut_dones == 5, "R9 five done pulses", dut_dones, 5);
        expect_fault(1'b0, "R6 no fault after good launches");

        cur_req = "R4";
        wr(4'd1, 8'h55); idle(1); wr(4'd1, 8'hAA); wr(4'd0, 8'h03);
        expect_fault(1'b1, "R4 gap rejected, R6 fault set");
        wr(4'd0, 8'h06);
        expect_fault(1'b0, "R6 fault cleared");

        wr(4'd1, 8'h55); wr(4'd1, 8'h5A); wr(4'd0, 8'h03);
        expect_fault(1'b1, "R4 wrong key rejected");
        wr(4'd0, 8'h06);
        wr(4'd1, 8'h55); wr(4'd1, 8'hAA); rd(4'd0); wr(4'd0, 8'h03);
        expect_fault(1'b1, "R4 intervening read rejected");
        wr(4'd0, 8'h06);
        chk(dut_rises == 5, "R4 no launches", dut_rises, 5);

        cur_req = "R3";
        wr(4'd0, 8'h00);
        unlock_go(8'h01);
        expect_fault(1'b1, "R3 enable clear rejected");
        wr(4'd0, 8'h04);
        unlock_go(8'h03);
        expect_fault(1'b1, "R3 enable only in start write rejected");
        wr(4'd0, 8'h06);
        chk(dut_rises == 5, "R3 no launches", dut_rises, 5);

        cur_req = "R5";
        wr(4'd1, 8'h55); unlock_go(8'h13);
        idle(25);
        wr(4'd1, 8'hAA); unlock_go(8'h23);
        idle(20);
        chk(dut_rises == 7, "R5 restart launches", dut_rises, 7);
        expect_fault(1'b0, "R5 no fault");

        cur_req = "R7";
        unlock_go(8'h53);
        expect_fault(1'b1, "R7 invalid op rejected");
        wr(4'd0, 8'h06);
        chk(dut_rises == 7, "R7 no launch", dut_rises, 7);

        cur_req = "R10";
        unlock_go(8'h03);
        idle(2);
        unlock_go(8'h33);
        idle(2);
        chk(op_o == 3'd0, "R10 op kept while busy", int'(op_o), 0);
        chk(stall_o == 1'b1, "R10 still busy", int'(stall_o), 1);
        idle(30);
        chk(bus_rdata[2] == 1'b1, "R10 start while busy faults", int'(bus_rdata[2]), 1);
        chk(dut_rises == 8, "R10 single launch", dut_rises, 8);
        chk(dut_dones == 8, "R9 done count", dut_dones, 8);
        wr(4'd0, 8'h06);
        idle(3);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wait (cycles > 20000);
        errors++;
        checks++;
        $display("FAIL watchdog expired at cycle %0d expected end before 20000", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule